// File: doc/BRIEF.md
# Pairwise-Order LRU Replacement Selector

This block keeps the replacement history of a four-way set-associative cache. Each set owns six history bits. Each bit records which way of one pair of ways was used less recently. From the six bits of the set on `set_idx`, the block works out which way a miss should evict. Every valid access rewrites the bits of that set so that the accessed way becomes the most recently used one.

Software can also load a set's history bits directly. The bits of the indexed set are visible on an output so that such a load can be read back. The victim output is combinational: it follows the stored bits and the index with no clock. Updates take effect at the next rising clock edge. Only the power-on reset clears the history, and it sets every set to all zeros.

Top module: `lru_pair_replacer`

## Requirements
- R1: While `por_rst_n` is low, and after it rises, every set holds history 6'b000000, which selects way 3 as the victim.
- R2: The history bits are indexed 5 down to 0. Bit 5 covers the way pair (0,1), bit 4 covers (0,2), bit 3 covers (0,3), bit 2 covers (1,2), bit 1 covers (1,3) and bit 0 covers (2,3). A 1 means the lower-numbered way of the pair is the older one.
- R3: `victim_way` names the way that is older than each of the other three ways under the encoding of R2. For example, way 0 is chosen when bits 5, 4 and 3 are all 1, and way 3 is chosen when bits 3, 1 and 0 are all 0.
- R4: When `acc_valid` is high at a rising edge and `sw_wr_en` is low, the indexed set is updated for the accessed way k. Every bit that pairs k with a higher way is cleared, every bit that pairs k with a lower way is set, and the other bits keep their values.
- R5: When both `acc_valid` and `sw_wr_en` are low at an edge, the history of the indexed set does not change.
- R6: When `sw_wr_en` is high at a rising edge, the indexed set takes the value of `sw_wr_data`. `lru_bits` shows the stored bits of the indexed set.
- R7: When `sw_wr_en` and `acc_valid` are high in the same cycle, the software load wins and the access is dropped.
- R8: An update or a load changes only the set selected by `set_idx`. All other sets keep their history.
- R9: `victim_way` and `lru_bits` follow a change of `set_idx` within the same cycle, with no clock edge needed.
- R10: If no way is older than all three others, as happens with a cyclic pattern such as 6'b100101, `victim_way` reports way 3. Among the 64 patterns, exactly 24 are consistent orderings. Each of these selects exactly one way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| por_rst_n | input | 1 | Power-on reset, asynchronous, active low; clears all history |
| set_idx | input | SET_W | Set selected for lookup, update and load |
| acc_valid | input | 1 | A cache access to the indexed set takes place this cycle |
| acc_way | input | 2 | Way touched by the access |
| sw_wr_en | input | 1 | Software load of the indexed set's history |
| sw_wr_data | input | 6 | History value to load |
| lru_bits | output | 6 | Stored history of the indexed set |
| victim_way | output | 2 | Way to replace on a miss in the indexed set |

## Verification
The bench builds the block with 16 sets instead of 256. This lets it sweep every set for the reset value and for isolation between sets within a short run. With the width of the history unchanged, it can load all 64 bit patterns and compare the victim with an ordering model. The same small array also keeps access chains over every way, collisions between load and access, and a second power-on reset in the middle of the run cheap to cover.

// File: rtl/lru_pkg.sv
package lru_pkg;
    localparam int LRU_W = 6;
    localparam int WAY_W = 2;

    typedef logic [LRU_W-1:0] lru_t;
    typedef logic [WAY_W-1:0] way_t;

    // A pattern is a consistent ordering when the four ages are all distinct.
    function automatic logic lru_is_order(input lru_t b);
        logic [1:0] a0, a1, a2, a3;
        a0 = 2'(b[5]) + 2'(b[4]) + 2'(b[3]);
        a1 = 2'(!b[5]) + 2'(b[2]) + 2'(b[1]);
        a2 = 2'(!b[4]) + 2'(!b[2]) + 2'(b[0]);
        a3 = 2'(!b[3]) + 2'(!b[1]) + 2'(!b[0]);
        return (a0 != a1) && (a0 != a2) && (a0 != a3) &&
               (a1 != a2) && (a1 != a3) && (a2 != a3);
    endfunction
endpackage

// File: rtl/lru_victim_dec.sv
module lru_victim_dec
    import lru_pkg::*;
(
    input  lru_t       hist,
    output logic [3:0] oldest,
    output way_t       victim
);
    always_comb begin
        oldest[0] =  hist[5] &  hist[4] &  hist[3];
        oldest[1] = ~hist[5] &  hist[2] &  hist[1];
        oldest[2] = ~hist[4] & ~hist[2] &  hist[0];
        oldest[3] = ~hist[3] & ~hist[1] & ~hist[0];
    end

    always_comb begin
        if (oldest[3])      victim = 2'd3;
        else if (oldest[2]) victim = 2'd2;
        else if (oldest[1]) victim = 2'd1;
        else if (oldest[0]) victim = 2'd0;
        else                victim = 2'd3;
    end
endmodule

// File: rtl/lru_touch_unit.sv
module lru_touch_unit
    import lru_pkg::*;
(
    input  lru_t cur,
    input  logic acc_valid,
    input  way_t acc_way,
    input  logic sw_wr_en,
    input  lru_t sw_wr_data,
    output logic upd_en,
    output lru_t nxt
);
    lru_t touched;

    always_comb begin
        touched = cur;
        unique case (acc_way)
            2'd0: begin touched[5] = 1'b0; touched[4] = 1'b0; touched[3] = 1'b0; end
            2'd1: begin touched[5] = 1'b1; touched[2] = 1'b0; touched[1] = 1'b0; end
            2'd2: begin touched[4] = 1'b1; touched[2] = 1'b1; touched[0] = 1'b0; end
            default: begin touched[3] = 1'b1; touched[1] = 1'b1; touched[0] = 1'b1; end
        endcase
    end

    always_comb begin
        upd_en = sw_wr_en | acc_valid;
        nxt    = sw_wr_en ? sw_wr_data : touched;
    end
endmodule

// File: rtl/lru_set_store.sv
module lru_set_store
    import lru_pkg::*;
#(
    parameter int NUM_SETS = 256,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic             wr_en,
    input  logic [SET_W-1:0] idx,
    input  lru_t             wr_bits,
    output lru_t             rd_bits
);
    typedef struct packed {
        lru_t [NUM_SETS-1:0] row;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.row[idx] = wr_bits;
    end

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign rd_bits = st_q.row[idx];
endmodule

// File: rtl/lru_pair_replacer.sv
module lru_pair_replacer
    import lru_pkg::*;
#(
    parameter int NUM_SETS = 256,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             acc_valid,
    input  logic [1:0]       acc_way,
    input  logic             sw_wr_en,
    input  logic [5:0]       sw_wr_data,
    output logic [5:0]       lru_bits,
    output logic [1:0]       victim_way
);
    lru_t       cur_hist;
    lru_t       nxt_hist;
    logic       upd_en;
    logic [3:0] oldest;
    way_t       vic;

    lru_set_store #(.NUM_SETS(NUM_SETS)) u_store (
        .clk      (clk),
        .por_rst_n(por_rst_n),
        .wr_en    (upd_en),
        .idx      (set_idx),
        .wr_bits  (nxt_hist),
        .rd_bits  (cur_hist)
    );

    lru_touch_unit u_touch (
        .cur       (cur_hist),
        .acc_valid (acc_valid),
        .acc_way   (acc_way),
        .sw_wr_en  (sw_wr_en),
        .sw_wr_data(sw_wr_data),
        .upd_en    (upd_en),
        .nxt       (nxt_hist)
    );

    lru_victim_dec u_dec (
        .hist  (cur_hist),
        .oldest(oldest),
        .victim(vic)
    );

    assign lru_bits   = cur_hist;
    assign victim_way = vic;

    AST_DECODE_UNIQUE: assert property (@(posedge clk) disable iff (!por_rst_n)
        lru_is_order(lru_bits) |-> ($countones(oldest) == 1)); // R10

    AST_ACC_NOT_VICTIM: assert property (@(posedge clk) disable iff (!por_rst_n)
        (acc_valid && !sw_wr_en && lru_is_order(lru_bits))
        |=> (!$stable(set_idx) || victim_way != $past(acc_way))); // R4

    AST_ACC_KEEPS_ORDER: assert property (@(posedge clk) disable iff (!por_rst_n)
        (acc_valid && !sw_wr_en && lru_is_order(lru_bits))
        |=> (!$stable(set_idx) || lru_is_order(lru_bits))); // R4

    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!por_rst_n)
        sw_wr_en |=> (!$stable(set_idx) || lru_bits == $past(sw_wr_data))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!acc_valid && !sw_wr_en) |=> (!$stable(set_idx) || $stable(lru_bits))); // R5
endmodule

// File: tb/lru_pair_replacer_tb.sv
module lru_pair_replacer_tb;
    localparam int SETS = 16;
    localparam int SW   = $clog2(SETS);

    logic          clk = 1'b0;
    logic          por_rst_n = 1'b0;
    logic [SW-1:0] set_idx = '0;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_way = '0;
    logic          sw_wr_en = 1'b0;
    logic [5:0]    sw_wr_data = '0;
    logic [5:0]    lru_bits;
    logic [1:0]    victim_way;

    int n_run = 0;
    int n_fail = 0;
    logic [5:0] mdl [SETS];
    logic [5:0] exp_bits [$];
    logic [1:0] exp_vic [$];
    string      exp_req [$];

    always #2 clk = ~clk;

    lru_pair_replacer #(.NUM_SETS(SETS)) u_dut (
        .clk(clk), .por_rst_n(por_rst_n), .set_idx(set_idx),
        .acc_valid(acc_valid), .acc_way(acc_way), .sw_wr_en(sw_wr_en),
        .sw_wr_data(sw_wr_data), .lru_bits(lru_bits), .victim_way(victim_way)
    );

    // Pair covered by each history bit (R2): lower and higher way.
    function automatic int pair_lo(input int b);
        case (b) 5, 4, 3: return 0; 2, 1: return 1; default: return 2; endcase
    endfunction
    function automatic int pair_hi(input int b);
        case (b) 5: return 1; 4, 2: return 2; default: return 3; endcase
    endfunction

    function automatic logic [5:0] m_touch(input logic [5:0] h, input int k);
        logic [5:0] r = h;
        for (int b = 0; b < 6; b++) begin
            if (pair_lo(b) == k) r[b] = 1'b0;
            if (pair_hi(b) == k) r[b] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [1:0] m_victim(input logic [5:0] h);
        for (int w = 0; w < 4; w++) begin
            bit all_old = 1;
            for (int b = 0; b < 6; b++) begin
                if (pair_lo(b) == w && !h[b]) all_old = 0;
                if (pair_hi(b) == w &&  h[b]) all_old = 0;
            end
            if (all_old) return 2'(w);
        end
        return 2'd3;
    endfunction

    task automatic check(input string req, input logic [5:0] eb, input logic [1:0] ev);
        n_run++;
        if (lru_bits !== eb || victim_way !== ev) begin
            n_fail++;
            $display("FAIL %s: bits=%b victim=%0d expected bits=%b victim=%0d",
                     req, lru_bits, victim_way, eb, ev);
        end
    endtask

    // Monitor: compares one expected item per cycle, after the update edge.
    always @(posedge clk) begin
        #1;
        if (exp_bits.size() > 0) begin
            logic [5:0] eb;
            logic [1:0] ev;
            string r;
            eb = exp_bits.pop_front();
            ev = exp_vic.pop_front();
            r  = exp_req.pop_front();
            check(r, eb, ev);
        end
    end

    // Driver: applies one operation and pushes the expected result.
    task automatic op(input string req, input int s, input bit av, input int w,
                      input bit we, input logic [5:0] wd);
        @(negedge clk);
        set_idx    = SW'(s);
        acc_valid  = av;
        acc_way    = 2'(w);
        sw_wr_en   = we;
        sw_wr_data = wd;
        if (we)      mdl[s] = wd;
        else if (av) mdl[s] = m_touch(mdl[s], w);
        exp_bits.push_back(mdl[s]);
        exp_vic.push_back(m_victim(mdl[s]));
        exp_req.push_back(req);
    endtask

    task automatic drain();
        @(negedge clk);
        acc_valid = 1'b0;
        sw_wr_en  = 1'b0;
        while (exp_bits.size() > 0) @(negedge clk);
    endtask

    task automatic power_on();
        por_rst_n = 1'b0;
        for (int s = 0; s < SETS; s++) mdl[s] = '0;
        repeat (3) @(negedge clk);
        por_rst_n = 1'b1;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        power_on();
        // R1: every set reads all zeros, victim way 3
        for (int s = 0; s < SETS; s++) op("R1", s, 0, 0, 0, '0);
        drain();

        // R4: chains of accesses over every way, in several orders
        for (int w = 0; w < 4; w++) op("R4", 1, 1, w, 0, '0);
        for (int w = 3; w >= 0; w--) op("R4", 2, 1, w, 0, '0);
        op("R4", 3, 1, 2, 0, '0); op("R4", 3, 1, 0, 0, '0);
        op("R4", 3, 1, 2, 0, '0); op("R4", 3, 1, 1, 0, '0);
        op("R4", 3, 1, 3, 0, '0);
        drain();

        // R5: idle cycles keep the history
        op("R5", 3, 0, 1, 0, 6'b010101);
        op("R5", 3, 0, 0, 0, '0);

        // R6, R3, R10: load every pattern and compare the decoded victim
        for (int p = 0; p < 64; p++) op("R3_R6_R10", 4, 0, 0, 1, 6'(p));
        op("R10", 5, 0, 0, 1, 6'b100101);
        drain();

        // R7: a load and an access in the same cycle, load wins
        op("R7", 6, 1, 0, 1, 6'b111000);
        op("R7", 6, 1, 3, 1, 6'b000110);
        drain();

        // R8: other sets unchanged after work on sets 1..6
        for (int s = 0; s < SETS; s++) op("R8", s, 0, 0, 0, '0);
        drain();

        // R9: outputs follow the index within the cycle
        @(negedge clk);
        set_idx = SW'(2);
        #0.5;
        check("R9", mdl[2], m_victim(mdl[2]));
        set_idx = SW'(4);
        #0.5;
        check("R9", mdl[4], m_victim(mdl[4]));

        // R1: second power-on reset clears state written above
        power_on();
        for (int s = 0; s < 8; s++) op("R1", s, 0, 0, 0, '0);
        drain();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule